// File: doc/BRIEF.md
# Accumulator Instruction Fetch-Execute Sequencer

This block is the timed controller and register set of a small single-address accumulator machine. Every register-to-register and register-to-memory transfer goes over one shared internal bus whose source is picked by a 3-bit select code. Words read from memory always land in the data register first, and words written to memory always leave from it. The sequencer runs a fixed chain of one-clock micro-steps: a three-step fetch, a decode step, and then one or two execute steps chosen by the opcode.

An instruction word holds a 4-bit opcode in its top bits and a 12-bit operand address below it. The supported operations are: load the accumulator from memory, add a memory word to the accumulator (recording the carry-out in a one-bit flag), multiply the accumulator by the scratch register, copy the accumulator to memory, copy the accumulator to the scratch register, and halt. Memory lives outside the block and is read combinationally at the address the block presents.

Top module: `acc_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, the accumulator, carry flag and program counter read zero, `halted` is low, no memory read or write is strobed, and the bus select shows the program counter (code 2).
- R2: Fetch takes three clocks. In the first step the bus carries the program counter (code 2) into the address register. In the second step memory is read at that address with the bus showing memory (code 7). In the third step the data register (code 3) feeds the instruction register, and the program counter goes up by one. The program counter never changes in any other way.
- R3: In the decode step the instruction register (code 5) drives the bus. The address register takes the low 12 bits (the operand address). Opcode bits 15:12 choose the next step.
- R4: Opcode 0 (load) reads memory at the operand address into the data register. The next clock passes it unchanged into the accumulator. The flag is left alone, and the instruction takes 6 clocks.
- R5: Opcode 1 (add) reads the operand into the data register. The next clock writes the 16-bit sum of accumulator and data register into the accumulator and stores the carry-out in the flag. The instruction takes 6 clocks.
- R6: Opcode 2 (multiply) moves the scratch register (code 6) over the bus into the data register. The next clock writes the low 16 bits of accumulator times data register into the accumulator. The instruction takes 6 clocks.
- R7: Opcode 3 (store to memory) moves the accumulator (code 4) into the data register. The next clock strobes the memory write at the operand address, with the data register (code 3) on the bus as write data. This is the only way a write is issued.
- R8: Opcode 4 (store to scratch) copies the accumulator (code 4) into the scratch register in a single execute step. The instruction takes 5 clocks.
- R9: Opcode F (halt) raises `halted` after decode. From then until reset the bus select is 0 (bus reads zero), no read or write is strobed, and the program counter holds.
- R10: Opcodes 5 to E return to fetch right after decode. They take 4 clocks, write nothing, and leave the accumulator and flag unchanged.
- R11: The accumulator changes only in the second execute step of load, add or multiply, when the bus select is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | DW (16) | Word read from memory at `mem_addr` |
| mem_addr | output | AW (12) | Memory address (address register) |
| mem_rd | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DW (16) | Write data (shared bus value) |
| bus_sel | output | 3 | Current bus source code |
| acc | output | DW (16) | Accumulator |
| e_flag | output | 1 | Carry flag from the last add |
| pc_out | output | AW (12) | Program counter |
| halted | output | 1 | Sequencer has stopped on a halt opcode |

## Verification
Two events share a clock in the last fetch step: the instruction register captures the fetched word and the program counter increments. Both read values from the same register state. Every program provokes this on each instruction, and it is judged by a cycle trace of `bus_sel`, `mem_addr` and `pc_out` across the first instruction, and by the final program counter sitting one past the halt word. The add step writes the accumulator and the carry flag in one clock. Sweeps with operands chosen to wrap past 16 bits judge it against sums, carries and products computed in the bench.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;
  localparam int OPW = 4;

  typedef enum logic [2:0] {
    BUS_NONE = 3'd0,
    BUS_AR   = 3'd1,
    BUS_PC   = 3'd2,
    BUS_DR   = 3'd3,
    BUS_AC   = 3'd4,
    BUS_IR   = 3'd5,
    BUS_TR   = 3'd6,
    BUS_MEM  = 3'd7
  } bus_src_e;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_MUL  = 2'd2
  } alu_op_e;

  typedef enum logic [2:0] {
    ST_F0, ST_F1, ST_F2, ST_DEC, ST_X1, ST_X2, ST_HALT
  } step_e;

  localparam logic [OPW-1:0] OPC_LOAD  = 4'h0;
  localparam logic [OPW-1:0] OPC_ADD   = 4'h1;
  localparam logic [OPW-1:0] OPC_MUL   = 4'h2;
  localparam logic [OPW-1:0] OPC_STM   = 4'h3;
  localparam logic [OPW-1:0] OPC_STT   = 4'h4;
  localparam logic [OPW-1:0] OPC_HALT  = 4'hF;

  typedef struct packed {
    bus_src_e sel;
    alu_op_e  alu;
    logic     ld_ar;
    logic     ld_dr;
    logic     ld_ac;
    logic     ld_ir;
    logic     ld_tr;
    logic     ld_e;
    logic     inc_pc;
    logic     mem_rd;
    logic     mem_we;
  } ctl_t;
endpackage

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_seq_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  output ctl_t           ctl,
  output logic           halted
);
  step_e step, nxt;

  always_ff @(posedge clk) begin
    if (rst) step <= ST_F0;
    else     step <= nxt;
  end

  always_comb begin
    ctl = '{sel: BUS_NONE, alu: ALU_PASS, default: 1'b0};
    nxt = step;
    case (step)
      ST_F0: begin
        ctl.sel = BUS_PC; ctl.ld_ar = 1'b1; nxt = ST_F1;
      end
      ST_F1: begin
        ctl.sel = BUS_MEM; ctl.mem_rd = 1'b1; ctl.ld_dr = 1'b1; nxt = ST_F2;
      end
      ST_F2: begin
        ctl.sel = BUS_DR; ctl.ld_ir = 1'b1; ctl.inc_pc = 1'b1; nxt = ST_DEC;
      end
      ST_DEC: begin
        ctl.sel = BUS_IR; ctl.ld_ar = 1'b1;
        case (opcode)
          OPC_LOAD, OPC_ADD, OPC_MUL, OPC_STM, OPC_STT: nxt = ST_X1;
          OPC_HALT: nxt = ST_HALT;
          default:  nxt = ST_F0;
        endcase
      end
      ST_X1: begin
        nxt = ST_X2;
        case (opcode)
          OPC_LOAD, OPC_ADD: begin
            ctl.sel = BUS_MEM; ctl.mem_rd = 1'b1; ctl.ld_dr = 1'b1;
          end
          OPC_MUL: begin
            ctl.sel = BUS_TR; ctl.ld_dr = 1'b1;
          end
          OPC_STM: begin
            ctl.sel = BUS_AC; ctl.ld_dr = 1'b1;
          end
          OPC_STT: begin
            ctl.sel = BUS_AC; ctl.ld_tr = 1'b1; nxt = ST_F0;
          end
          default: nxt = ST_F0;
        endcase
      end
      ST_X2: begin
        nxt = ST_F0;
        case (opcode)
          OPC_LOAD: begin ctl.ld_ac = 1'b1; ctl.alu = ALU_PASS; end
          OPC_ADD:  begin ctl.ld_ac = 1'b1; ctl.alu = ALU_ADD; ctl.ld_e = 1'b1; end
          OPC_MUL:  begin ctl.ld_ac = 1'b1; ctl.alu = ALU_MUL; end
          OPC_STM:  begin ctl.sel = BUS_DR; ctl.mem_we = 1'b1; end
          default:  ;
        endcase
      end
      ST_HALT: nxt = ST_HALT;
      default: nxt = ST_F0;
    endcase
  end

  assign halted = (step == ST_HALT);
endmodule

// File: rtl/acc_seq_bus.sv
module acc_seq_bus
  import acc_seq_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  bus_src_e        sel,
  input  logic [AW-1:0]   ar,
  input  logic [AW-1:0]   pc,
  input  logic [DW-1:0]   dr,
  input  logic [DW-1:0]   ac,
  input  logic [DW-1:0]   ir,
  input  logic [DW-1:0]   tr,
  input  logic [DW-1:0]   mem,
  output logic [DW-1:0]   bus
);
  localparam int PADW = DW - AW;

  always_comb begin
    case (sel)
      BUS_AR:  bus = {{PADW{1'b0}}, ar};
      BUS_PC:  bus = {{PADW{1'b0}}, pc};
      BUS_DR:  bus = dr;
      BUS_AC:  bus = ac;
      BUS_IR:  bus = ir;
      BUS_TR:  bus = tr;
      BUS_MEM: bus = mem;
      default: bus = '0;
    endcase
  end
endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu
  import acc_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output logic          carry
);
  logic [DW:0]   sum;
  logic [DW-1:0] prod;

  assign sum  = {1'b0, a} + {1'b0, b};
  assign prod = a * b;

  always_comb begin
    carry = 1'b0;
    case (op)
      ALU_ADD: begin res = sum[DW-1:0]; carry = sum[DW]; end
      ALU_MUL: res = prod;
      default: res = b;
    endcase
  end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_seq_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic [2:0]    bus_sel,
  output logic [DW-1:0] acc,
  output logic          e_flag,
  output logic [AW-1:0] pc_out,
  output logic          halted
);
  localparam logic [AW-1:0] PC_STEP = AW'(1);

  ctl_t          ctl;
  logic [AW-1:0] ar_q, pc_q;
  logic [DW-1:0] dr_q, ac_q, ir_q, tr_q;
  logic          e_q;
  logic [DW-1:0] bus;
  logic [DW-1:0] alu_res;
  logic          alu_carry;

  acc_seq_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (ir_q[DW-1 -: OPW]),
    .ctl    (ctl),
    .halted (halted)
  );

  acc_seq_bus #(.AW(AW), .DW(DW)) u_bus (
    .sel (ctl.sel),
    .ar  (ar_q),
    .pc  (pc_q),
    .dr  (dr_q),
    .ac  (ac_q),
    .ir  (ir_q),
    .tr  (tr_q),
    .mem (mem_rdata),
    .bus (bus)
  );

  acc_seq_alu #(.DW(DW)) u_alu (
    .op    (ctl.alu),
    .a     (ac_q),
    .b     (dr_q),
    .res   (alu_res),
    .carry (alu_carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ar_q <= '0;
      pc_q <= '0;
      dr_q <= '0;
      ac_q <= '0;
      ir_q <= '0;
      tr_q <= '0;
      e_q  <= 1'b0;
    end else begin
      if (ctl.ld_ar)  ar_q <= bus[AW-1:0];
      if (ctl.inc_pc) pc_q <= pc_q + PC_STEP;
      if (ctl.ld_dr)  dr_q <= bus;
      if (ctl.ld_ir)  ir_q <= bus;
      if (ctl.ld_tr)  tr_q <= bus;
      if (ctl.ld_ac)  ac_q <= alu_res;
      if (ctl.ld_e)   e_q  <= alu_carry;
    end
  end

  assign mem_addr  = ar_q;
  assign mem_rd    = ctl.mem_rd;
  assign mem_we    = ctl.mem_we;
  assign mem_wdata = bus;
  assign bus_sel   = ctl.sel;
  assign acc       = ac_q;
  assign e_flag    = e_q;
  assign pc_out    = pc_q;
endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk
  import acc_seq_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    bus_sel,
  input logic          mem_rd,
  input logic          mem_we,
  input logic [AW-1:0] pc,
  input logic [DW-1:0] acc,
  input logic          e_flag,
  input logic          halted
);
  p_fetch_read_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_sel == BUS_PC && !halted) |=> (mem_rd && bus_sel == BUS_MEM));

  p_read_src_r2: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (bus_sel == BUS_MEM && !mem_we));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && pc != $past(pc)) |-> (pc == $past(pc) + AW'(1) && $past(bus_sel) == BUS_DR));

  p_write_src_r7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (bus_sel == BUS_DR && !halted));

  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !mem_we && !mem_rd && $stable(pc) && bus_sel == BUS_NONE));

  p_acc_step_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && acc != $past(acc)) |-> ($past(bus_sel) == BUS_NONE && !$past(halted)));

  p_flag_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && e_flag != $past(e_flag)) |-> ($past(bus_sel) == BUS_NONE && !$past(halted)));
endmodule

bind acc_seq acc_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bus_sel (bus_sel),
  .mem_rd  (mem_rd),
  .mem_we  (mem_we),
  .pc      (pc_out),
  .acc     (acc),
  .e_flag  (e_flag),
  .halted  (halted)
);

// File: tb/acc_seq_tb.sv
`timescale 1ns/1ps
module acc_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_rdata;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_we;
  logic [15:0] mem_wdata;
  logic [2:0]  bus_sel;
  logic [15:0] acc;
  logic        e_flag;
  logic [11:0] pc_out;
  logic        halted;

  logic [15:0] mem [0:255];
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];

  acc_seq u_dut (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .bus_sel(bus_sel), .acc(acc), .e_flag(e_flag), .pc_out(pc_out),
    .halted(halted)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
    return {op, a};
  endfunction

  task automatic clear_mem();
    for (int k = 0; k < 256; k++) mem[k] = 16'h0;
  endtask

  // Runs the loaded program from reset until halt; traces the first fetch.
  task automatic run_prog(output int cyc, output int nwr,
                          output logic [11:0] waddr, output logic [15:0] wdata);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cyc = 0; nwr = 0; waddr = '0; wdata = '0;
    chk("R1 reset bus select", {29'd0, bus_sel}, 32'd2);
    chk("R1 reset strobes/state", {mem_rd, mem_we, halted, e_flag, pc_out, acc},
        32'd0);
    while (!halted && cyc < 500) begin
      if (mem_we) begin
        nwr++; waddr = mem_addr; wdata = mem_wdata;
        mem[mem_addr[7:0]] = mem_wdata;
      end
      @(posedge clk);
      cyc++;
      @(negedge clk);
      case (cyc)
        1: chk("R2 fetch read step", {bus_sel, mem_rd, mem_addr}, {3'd7, 1'b1, 12'h000});
        2: chk("R2 fetch copy step", {bus_sel, mem_rd, pc_out}, {3'd3, 1'b0, 12'h000});
        3: chk("R3 decode step", {bus_sel, pc_out}, {3'd5, 12'h001});
        4: chk("R3 operand address", {bus_sel, mem_rd, mem_addr}, {3'd7, 1'b1, 12'h040});
        default: ;
      endcase
    end
    if (cyc >= 500) chk("R9 halt reached", 32'd0, 32'd1);
  endtask

  task automatic halt_hold(input logic [11:0] pc_exp);
    bit quiet = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (!halted || mem_we || mem_rd || bus_sel != 3'd0 || pc_out != pc_exp) quiet = 1'b0;
    end
    chk("R9 halted stays quiet", {31'd0, quiet}, 32'd1);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc, nwr;
    logic [11:0] waddr;
    logic [15:0] wdata;
    // Sweep: X = (A+B)*(C+D)
    for (int i = 0; i < 16; i++) begin
      logic [15:0] a, b, c, d, t, x;
      logic [16:0] s1, s2;
      a = 16'(i * 32'h1357);
      b = 16'(i * 32'hE0F1 + 5);
      c = 16'hFFFF - 16'(i);
      d = 16'(i * i + 1);
      s1 = {1'b0, a} + {1'b0, b};
      s2 = {1'b0, c} + {1'b0, d};
      t = s1[15:0];
      x = 16'(s2[15:0] * t);
      clear_mem();
      mem[0] = ins(4'h0, 12'h040);
      mem[1] = ins(4'h1, 12'h041);
      mem[2] = ins(4'h4, 12'h000);
      mem[3] = ins(4'h0, 12'h042);
      mem[4] = ins(4'h1, 12'h043);
      mem[5] = ins(4'h2, 12'h000);
      mem[6] = ins(4'h3, 12'h050);
      mem[7] = ins(4'hF, 12'h000);
      mem[8'h40] = a; mem[8'h41] = b; mem[8'h42] = c; mem[8'h43] = d;
      run_prog(cyc, nwr, waddr, wdata);
      chk("R4 R5 R6 R8 total clocks", cyc, 45);
      chk("R6 product in accumulator", {16'd0, acc}, {16'd0, x});
      chk("R5 carry of last add", {31'd0, e_flag}, {31'd0, s2[16]});
      chk("R7 single write", nwr, 1);
      chk("R7 write address/data", {4'd0, waddr, wdata}, {4'd0, 12'h050, x});
      chk("R7 memory holds result", {16'd0, mem[8'h50]}, {16'd0, x});
      chk("R2 pc after halt", {20'd0, pc_out}, 32'd8);
      halt_hold(12'd8);
    end
    // Opcodes 5..E are skipped
    for (int op = 5; op < 15; op++) begin
      clear_mem();
      mem[0] = ins(4'h0, 12'h040);
      mem[1] = ins(4'h1, 12'h041);
      mem[2] = ins(4'(op), 12'h041);
      mem[3] = ins(4'h3, 12'h050);
      mem[4] = ins(4'hF, 12'h000);
      mem[8'h40] = 16'hFFFF; mem[8'h41] = 16'h0001; mem[8'h50] = 16'hABCD;
      run_prog(cyc, nwr, waddr, wdata);
      chk("R10 skipped opcode clocks", cyc, 26);
      chk("R10 accumulator/flag kept", {15'd0, e_flag, acc}, {15'd0, 1'b1, 16'h0000});
      chk("R10 no extra write", nwr, 1);
      chk("R10 operand untouched", {16'd0, mem[8'h41]}, 32'h1);
      chk("R7 stored value", {16'd0, mem[8'h50]}, 32'h0);
      halt_hold(12'd5);
    end
    // Load leaves the flag alone
    clear_mem();
    mem[0] = ins(4'h0, 12'h040);
    mem[1] = ins(4'h1, 12'h041);
    mem[2] = ins(4'h0, 12'h042);
    mem[3] = ins(4'hF, 12'h000);
    mem[8'h40] = 16'h8000; mem[8'h41] = 16'h8001; mem[8'h42] = 16'h1234;
    run_prog(cyc, nwr, waddr, wdata);
    chk("R4 load keeps flag", {15'd0, e_flag, acc}, {15'd0, 1'b1, 16'h1234});
    chk("R4 load clocks", cyc, 22);
    chk("R11 no write", nwr, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule